// File: doc/BRIEF.md
# Dual-Mode Ranked Interrupt Router

This block gathers eight request lines into a single pending set, ranks the unmasked pending requests, and presents the winners on three output ports. Port A serves a primary processor. Ports B and C serve a secondary processor. Every port shows an encoded level together with a valid flag. The presented level stays pending until the serving processor pulses that port's acknowledge. Masking hides a request from the ports, but it does not stop the request from being recorded.

A mode input selects between two fixed priority orders and two routing schemes. In normal mode the two processors work in parallel. Port A carries the best-ranked eligible request, port B carries the runner-up, and port C stays idle. In survival mode the secondary processor takes every level except the most urgent one, through ports B and C. Port A is reserved for that most urgent level, so the primary processor can deal with it at once.

The mode and the mask are both sampled on the clock edge. A change to either one re-ranks everything that is already pending, starting on the next cycle.

Top module: `pic_mode_router`

## Requirements
- R1: While reset is asserted and after it is released with no request, every port valid flag is 0, every level output is 0 and nothing is pending.
- R2: A request bit seen high at a clock edge becomes pending and stays pending until it is acknowledged. If a request and an acknowledge for the same level fall in the same cycle, the level stays pending.
- R3: A masked pending level is never presented on any port. It is kept pending and appears in the cycle after its mask bit is sampled low.
- R4: In normal mode (mode input 0), level codes rank 0 highest through 7 lowest. Request bit i carries level code i. Port A presents the best-ranked eligible code, port B presents the second-best, and port C valid is 0.
- R5: In survival mode (mode input 1), port A presents only code 0 (valid when code 0 is eligible). Ports B and C present the best and second-best of the other eligible codes, ranked in the order 1, 5, 6, 3, 4, 2, 7.
- R6: An acknowledge pulse on a port whose valid flag is high clears the level presented by that port at the following edge. An acknowledge on a port whose valid flag is low has no effect.
- R7: A better-ranked request that arrives while a level is presented displaces that level from its port. The displaced level stays pending and is presented again once the better one is acknowledged.
- R8: The mode input is sampled at the clock edge. In the cycle after a change, all pending levels are ranked and routed under the new mode.
- R9: State changes caused by the edge at which req, mask, mode or ack are sampled are visible on the port outputs in the same cycle, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_surv | input | 1 | 0 selects normal mode, 1 selects survival mode |
| req | input | 8 | Request lines, bit i is level code i |
| mask | input | 8 | Mask bits, 1 hides level code i from the ports |
| a_ack | input | 1 | Acknowledge pulse for port A |
| b_ack | input | 1 | Acknowledge pulse for port B |
| c_ack | input | 1 | Acknowledge pulse for port C |
| a_valid | output | 1 | Port A holds a level |
| a_lvl | output | 3 | Port A level code |
| b_valid | output | 1 | Port B holds a level |
| b_lvl | output | 3 | Port B level code |
| c_valid | output | 1 | Port C holds a level |
| c_lvl | output | 3 | Port C level code |

## Verification
A new request and an acknowledge can hit the same level in the same cycle. The bench provokes this by raising the request again while the port still presents that level and pulsing the acknowledge in the same cycle. It passes only if the level is still presented afterwards, and a later acknowledge alone must then clear it. A mode change can also coincide with acknowledges and new requests during a long pseudo-random run. There, a cycle-accurate model in the bench predicts all six port fields on every cycle. The bench also sweeps every pending pattern in both modes, starting each pattern from reset.

// File: rtl/pic_pkg.sv
// Package: shared constants, level type and the fixed survival-mode order.
// Assumes exactly eight levels; the survival order is part of behaviour.
package pic_pkg;
    localparam int NLEV = 8;
    localparam int LW   = $clog2(NLEV);

    typedef logic [LW-1:0] lvl_t;

    // Survival mode: level code held at rank position r (rank 0 is best).
    function automatic lvl_t surv_level_at(input int r);
        case (r)
            0:       return lvl_t'(0);
            1:       return lvl_t'(1);
            2:       return lvl_t'(5);
            3:       return lvl_t'(6);
            4:       return lvl_t'(3);
            5:       return lvl_t'(4);
            6:       return lvl_t'(2);
            default: return lvl_t'(7);
        endcase
    endfunction
endpackage

// File: rtl/pic_pend_bank.sv
// Pending store: one bit per level, set by a request and cleared by an
// acknowledge. Assumes set has priority over clear for the same bit.
module pic_pend_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    // Update the pending bits on each clock; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/pic_pick2.sv
// Finds the first and second set bits of a rank-ordered vector, where
// index 0 is the best rank. Purely combinational.
module pic_pick2 #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    output logic         f_valid_o,
    output logic [W-1:0] f_idx_o,
    output logic         s_valid_o,
    output logic [W-1:0] s_idx_o
);
    // Scan from the best rank down and keep the first two hits.
    always_comb begin
        f_valid_o = 1'b0;
        s_valid_o = 1'b0;
        f_idx_o   = '0;
        s_idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                if (!f_valid_o) begin
                    f_valid_o = 1'b1;
                    f_idx_o   = W'(i);
                end else if (!s_valid_o) begin
                    s_valid_o = 1'b1;
                    s_idx_o   = W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/pic_mode_router.sv
// Top: registers the mode and the mask, keeps the pending set, ranks the
// eligible levels under the selected order and routes the winners to
// ports A, B and C. Assumes each acknowledge is a single-cycle pulse.
module pic_mode_router
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_surv,
    input  logic [NLEV-1:0] req,
    input  logic [NLEV-1:0] mask,
    input  logic            a_ack,
    input  logic            b_ack,
    input  logic            c_ack,
    output logic            a_valid,
    output logic [LW-1:0]   a_lvl,
    output logic            b_valid,
    output logic [LW-1:0]   b_lvl,
    output logic            c_valid,
    output logic [LW-1:0]   c_lvl
);
    logic            mode_q;
    logic [NLEV-1:0] mask_q;
    logic [NLEV-1:0] pend;
    logic [NLEV-1:0] clr;
    logic [NLEV-1:0] elig;
    logic [NLEV-1:0] ord;
    logic            f_v, s_v;
    lvl_t            f_r, s_r;

    // Sample the mode and the mask on the clock edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            mask_q <= '0;
        end else begin
            mode_q <= mode_surv;
            mask_q <= mask;
        end
    end

    pic_pend_bank #(.N(NLEV)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (req),
        .clr_i (clr),
        .pend_o(pend)
    );

    assign elig = pend & ~mask_q;

    // Put eligible levels in rank order; in survival mode rank 0 (code 0)
    // is left out of the secondary ranking.
    for (genvar r = 0; r < NLEV; r++) begin : g_ord
        if (r == 0) begin : g_top
            assign ord[r] = mode_q ? 1'b0 : elig[r];
        end else begin : g_rest
            assign ord[r] = mode_q ? elig[surv_level_at(r)] : elig[r];
        end
    end

    pic_pick2 #(.N(NLEV), .W(LW)) u_pick (
        .vec_i    (ord),
        .f_valid_o(f_v),
        .f_idx_o  (f_r),
        .s_valid_o(s_v),
        .s_idx_o  (s_r)
    );

    // Convert rank positions back to level codes and route them to ports.
    always_comb begin
        if (mode_q) begin
            a_valid = elig[0];
            a_lvl   = '0;
            b_valid = f_v;
            b_lvl   = surv_level_at(int'(f_r));
            c_valid = s_v;
            c_lvl   = surv_level_at(int'(s_r));
        end else begin
            a_valid = f_v;
            a_lvl   = f_r;
            b_valid = s_v;
            b_lvl   = s_r;
            c_valid = 1'b0;
            c_lvl   = '0;
        end
    end

    // Build the clear vector from acknowledges on ports that are valid.
    always_comb begin
        clr = '0;
        if (a_valid && a_ack) clr[a_lvl] = 1'b1;
        if (b_valid && b_ack) clr[b_lvl] = 1'b1;
        if (c_valid && c_ack) clr[c_lvl] = 1'b1;
    end

    // R2: a sampled request is pending after the edge
    p_req_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |=> ((pend & $past(req)) == $past(req)));

    // R6: an acknowledged level without a new request is cleared
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ack && !req[a_lvl]) |=> !pend[$past(a_lvl)]);

    // R3: a port never shows a masked level
    p_masked_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid |-> !mask_q[b_lvl]) and (a_valid |-> !mask_q[a_lvl]));

    // R4: port C idle in normal mode; A and B never share a level
    p_port_c_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !c_valid);
    p_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid) |-> (a_lvl != b_lvl));

    // R5: in survival mode port A carries only code 0, B and C differ
    p_surv_primary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && a_valid) |-> (a_lvl == '0));
    p_surv_bc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && b_valid && c_valid) |-> (b_lvl != c_lvl && b_lvl != '0));
endmodule

// File: tb/pic_mode_router_tb.sv
`timescale 1ns/1ps
module pic_mode_router_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_surv = 1'b0;
    logic [7:0] req = '0, mask = '0;
    logic       a_ack = 1'b0, b_ack = 1'b0, c_ack = 1'b0;
    logic       a_valid, b_valid, c_valid;
    logic [2:0] a_lvl, b_lvl, c_lvl;

    int checks = 0, fails = 0;
    bit done = 0;

    // Bench model state.
    logic [7:0]  m_pend = '0, m_mask = '0;
    logic        m_mode = 1'b0;
    logic [11:0] m_out;

    always #4 clk = ~clk;

    pic_mode_router u_dut (
        .clk(clk), .rst_n(rst_n), .mode_surv(mode_surv), .req(req), .mask(mask),
        .a_ack(a_ack), .b_ack(b_ack), .c_ack(c_ack),
        .a_valid(a_valid), .a_lvl(a_lvl), .b_valid(b_valid), .b_lvl(b_lvl),
        .c_valid(c_valid), .c_lvl(c_lvl)
    );

    // Survival rank of each level code (R5): order 0,1,5,6,3,4,2,7.
    function automatic int srank(input int code);
        int t[8] = '{0, 1, 6, 4, 5, 2, 3, 7};
        return t[code];
    endfunction

    // Expected port fields {a_v,a_l,b_v,b_l,c_v,c_l} from the requirements.
    function automatic logic [11:0] expect_out(input logic [7:0] p, input logic [7:0] mk,
                                               input logic md);
        logic [7:0] e;
        int best, second, rb, rs;
        logic [11:0] o;
        e = p & ~mk;
        best = -1; second = -1; rb = 99; rs = 99;
        for (int c = 0; c < 8; c++) begin
            int rk;
            if (e[c] && !(md && c == 0)) begin
                rk = md ? srank(c) : c;
                if (rk < rb) begin
                    second = best; rs = rb; best = c; rb = rk;
                end else if (rk < rs) begin
                    second = c; rs = rk;
                end
            end
        end
        o = '0;
        if (md) begin
            o[11] = e[0];
            if (best >= 0)   o[7:4] = {1'b1, 3'(best)};
            if (second >= 0) o[3:0] = {1'b1, 3'(second)};
        end else begin
            if (best >= 0)   o[11:8] = {1'b1, 3'(best)};
            if (second >= 0) o[7:4]  = {1'b1, 3'(second)};
        end
        return o;
    endfunction

    function automatic logic [11:0] dut_out();
        return {a_valid, a_lvl, b_valid, b_lvl, c_valid, c_lvl};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [11:0] act,
                         input logic [11:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare after the edge.
    task automatic cyc(input logic [7:0] r, input logic [7:0] mk, input logic md,
                       input logic aa, input logic ba, input logic ca, input string tag);
        logic [7:0] clr;
        req = r; mask = mk; mode_surv = md; a_ack = aa; b_ack = ba; c_ack = ca;
        m_out = expect_out(m_pend, m_mask, m_mode);
        clr = '0;
        if (m_out[11] && aa) clr[m_out[10:8]] = 1'b1;
        if (m_out[7]  && ba) clr[m_out[6:4]]  = 1'b1;
        if (m_out[3]  && ca) clr[m_out[2:0]]  = 1'b1;
        @(posedge clk);
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_mode = 1'b0;
        end else begin
            m_pend = (m_pend & ~clr) | r; m_mask = mk; m_mode = md;
        end
        @(negedge clk);
        m_out = expect_out(m_pend, m_mask, m_mode);
        check(dut_out() === m_out, tag, dut_out(), m_out);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        logic [15:0] lf;
        logic [7:0]  rq, mk;
        logic        md;
        @(negedge clk);
        // R1: outputs idle during and after reset
        do_reset();
        check(dut_out() === 12'h000, "R1 idle in reset", dut_out(), 12'h000);
        cyc(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R1 idle after reset");

        // R4 / R5 / R9: every pending pattern in both modes, from reset
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 256; p++) begin
                do_reset();
                cyc(8'(p), 8'h00, 1'(m), 1'b0, 1'b0, 1'b0, m ? "R5 sweep" : "R4 sweep");
            end
        end

        // R2: request and acknowledge of the same level in one cycle
        do_reset();
        cyc(8'h08, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R2 set");
        cyc(8'h08, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R2 same cycle");
        check(a_valid === 1'b1 && a_lvl === 3'd3, "R2 level kept", dut_out(), 12'hB00);
        cyc(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R6 ack clears");
        check(a_valid === 1'b0, "R6 cleared", dut_out(), 12'h000);

        // R3 / R6: masked level latched, ack with valid low ignored
        do_reset();
        cyc(8'h01, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, "R3 masked");
        cyc(8'h00, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, "R6 ack while idle");
        cyc(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R3 unmask");
        check(a_valid === 1'b1 && a_lvl === 3'd0, "R3 delivered", dut_out(), 12'h800);

        // R7: preemption and resumption
        do_reset();
        cyc(8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R7 first");
        cyc(8'h02, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R7 preempt");
        check(a_lvl === 3'd1 && b_lvl === 3'd4 && b_valid, "R7 displaced", dut_out(), 12'h9C0);
        cyc(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R7 resume");
        check(a_valid && a_lvl === 3'd4, "R7 resumed", dut_out(), 12'hC00);

        // R8: mode switch re-ranks what is pending
        do_reset();
        cyc(8'h7E, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R8 normal");
        cyc(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R8 switched");
        check(b_lvl === 3'd1 && c_lvl === 3'd5 && !a_valid, "R8 survival order",
              dut_out(), 12'h09D);

        // R2 R3 R6 R7 R8: long pseudo-random run against the model
        lf = 16'hACE1; mk = '0; md = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rq = (lf[2:0] == 3'd0) ? 8'(1 << lf[6:4]) : 8'h00;
            if (lf[11:8] == 4'd0) mk = lf[7:0] & lf[15:8];
            if (lf[15:12] == 4'd0) md = ~md;
            cyc(rq, mk, md, lf[13], lf[14], lf[9], "R7 random run");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule